// File: doc/BRIEF.md
# Boot Failover Watchdog Controller

This block sits in board glue logic and guards the early boot phase, before the processor has set up its own watchdog. It arms itself as soon as power-on reset or an external board reset is released, and counts down a timeout of about half a second (default 62,500,000 cycles of a 125 MHz clock). If firmware has not disarmed it by the end of the count, it raises a fixed-length board reset pulse. In the same cycle it steps a persistent boot-device index, so that the next boot attempt fetches its image from the next flash device in a fixed order. This expire, reset and advance loop repeats until an image disarms the watchdog with a single register write.

The boot-device index and a sticky "has expired" flag live in the power-on reset domain only. They survive both watchdog-caused and external board resets. A mezzanine-present input, passed through a synchroniser, forces the watchdog off while it is asserted. A status word reports the armed state, the forced-off state, the sticky flag and the current boot-device index.

Top module: `bootfail_wdog`

## Requirements
- R1: After the last clock edge that samples `por_n` or `brd_rst_n` low, and after the end of any reset pulse, `reset_req` rises following exactly TIMEOUT_CYC further clock edges, unless the watchdog has been disarmed or forced off.
- R2: `reset_req` stays high for exactly PULSE_CYC cycles. The countdown then reloads, so the next rise comes TIMEOUT_CYC edges after the edge that ends the pulse.
- R3: Each expiry steps `boot_sel` by one in the order 0, 1, …, NUM_DEV-1, then back to 0. The step takes effect on the same edge that raises `reset_req`, and `boot_sel` changes at no other time except power-on reset.
- R4: `boot_sel` and the expired flag keep their values through external board resets and watchdog resets. Only `por_n` low returns them to 0.
- R5: A single-cycle `disarm_we` while the countdown runs stops the watchdog. It stays disarmed until the next external or power-on reset, and further writes change nothing.
- R6: A disarm write sampled on the same edge on which the count would expire wins: no pulse is raised and `boot_sel` is unchanged.
- R7: An external reset sampled on the same edge on which the count would expire wins: no pulse is raised, `boot_sel` is unchanged, and the countdown restarts from its release.
- R8: While the synchronised `mezz_present` (SYNC_STAGES edges of delay) is high, the watchdog never raises `reset_req` or changes `boot_sel`. The countdown holds at its full value and starts again when the input drops.
- R9: The bit positions of `status` are: bit 0 = armed (1 unless disarmed), bit 1 = forced off, bit 2 = expired flag, and bits [3 +: SEL_W] = boot-device index. After power-on reset the value is 1.
- R10: The expired flag is set on the edge of the first expiry and stays set.
- R11: A disarm write that arrives while the reset pulse is active is ignored. The watchdog stays armed and expires again after the next countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| brd_rst_n | input | 1 | External board reset, active low, synchronous; re-arms the countdown only |
| disarm_we | input | 1 | One-cycle register write strobe that disarms the watchdog |
| mezz_present | input | 1 | Asynchronous mezzanine-present level; forces the watchdog off |
| reset_req | output | 1 | Board reset request pulse |
| boot_sel | output | SEL_W | Index of the flash device to boot from |
| status | output | 3+SEL_W | {boot index, expired, forced off, armed} |

## Verification
Two events can land on the same edge. The final count of the timeout can coincide with a disarm write, and it can coincide with the external board reset. The bench provokes each case by timing the strobe, or the reset assertion, to be sampled on exactly the TIMEOUT_CYC-th edge after re-arming. It judges the result by showing that no reset pulse appears, that `boot_sel` keeps its value, and that the armed bit (or a fresh countdown measured from the reset release) matches what the winning event implies.

// File: rtl/bfw_pkg.sv
// Package: shared types for the boot failover watchdog.
// Assumes: a single clock domain for all users.
package bfw_pkg;

    // Watchdog sequencer states
    typedef enum logic [1:0] {
        WD_COUNT = 2'd0,   // armed, counting down
        WD_PULSE = 2'd1,   // driving the board reset pulse
        WD_OFF   = 2'd2    // disarmed by software
    } wd_state_e;

    // Fixed bit positions in the status word
    localparam int ST_ARMED   = 0;
    localparam int ST_FORCED  = 1;
    localparam int ST_EXPIRED = 2;
    localparam int ST_SEL_LSB = 3;

endpackage

// File: rtl/bfw_sync.sv
// Module: bfw_sync
// Brings an asynchronous level into the clock domain through STAGES
// flops. STAGES = 0 selects a plain wire, for inputs already synchronous.
// Assumes: synchronous active-low reset; reset value is 0.
module bfw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;

            // Shift the input level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d};
                end
            end

            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/bfw_timer.sv
// Module: bfw_timer
// Countdown and reset-pulse sequencer. Counts TIMEOUT_CYC edges, then
// drives a PULSE_CYC-cycle reset request and re-arms. A disarm write
// during the countdown parks it in the OFF state until a reset. Priority
// on a shared edge: reset first, then disarm, then forced-off, then expiry.
// Assumes: TIMEOUT_CYC >= 2, PULSE_CYC >= 1, 'forced' already synchronous.
module bfw_timer
    import bfw_pkg::*;
#(
    parameter int TIMEOUT_CYC = 62_500_000,
    parameter int PULSE_CYC   = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic brd_rst_n,
    input  logic disarm_we,
    input  logic forced,
    output logic expire_o,
    output logic reset_req_o,
    output logic armed_o
);

    localparam int CNT_W  = $clog2(TIMEOUT_CYC);
    localparam int PCNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0]  CNT_RELOAD  = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [PCNT_W-1:0] PULSE_RELOAD = PCNT_W'(PULSE_CYC - 1);

    wd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic              in_reset;
    logic              expire;

    assign in_reset = !por_n || !brd_rst_n;

    // Next-state decision and expiry detection
    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        case (state_q)
            WD_COUNT: begin
                if (disarm_we) begin
                    state_d = WD_OFF;
                end else if (!forced && (cnt_q == '0)) begin
                    state_d = WD_PULSE;
                    expire  = 1'b1;
                end
            end
            WD_PULSE: begin
                if (pcnt_q == '0) begin
                    state_d = WD_COUNT;
                end
            end
            WD_OFF: begin
                state_d = WD_OFF;
            end
            default: begin
                state_d = WD_COUNT;
            end
        endcase
    end

    // Sequencer state register; either reset re-arms the countdown
    always_ff @(posedge clk) begin
        if (in_reset) begin
            state_q <= WD_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Timeout down-counter; held full while forced off or pulsing
    always_ff @(posedge clk) begin
        if (in_reset) begin
            cnt_q <= CNT_RELOAD;
        end else if (state_q == WD_COUNT) begin
            if (forced) begin
                cnt_q <= CNT_RELOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (state_q == WD_PULSE) begin
            cnt_q <= CNT_RELOAD;
        end
    end

    // Reset-pulse length counter, loaded on expiry
    always_ff @(posedge clk) begin
        if (in_reset) begin
            pcnt_q <= '0;
        end else if (expire) begin
            pcnt_q <= PULSE_RELOAD;
        end else if ((state_q == WD_PULSE) && (pcnt_q != '0)) begin
            pcnt_q <= pcnt_q - 1'b1;
        end
    end

    assign expire_o    = expire && !in_reset;
    assign reset_req_o = (state_q == WD_PULSE);
    assign armed_o     = (state_q != WD_OFF);

endmodule

// File: rtl/bfw_bootsel.sv
// Module: bfw_bootsel
// Persistent boot-device index and sticky expired flag. Both live in
// the power-on domain only, so board resets leave them untouched. Each
// advance steps the index with wrap from NUM_DEV-1 to 0.
// Assumes: 'advance' is a single-cycle strobe, NUM_DEV >= 1.
module bfw_bootsel #(
    parameter int NUM_DEV = 3,
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             advance,
    output logic [SEL_W-1:0] sel_o,
    output logic             expired_o
);

    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_DEV - 1);

    logic [SEL_W-1:0] sel_q;
    logic             expired_q;

    // Step the device index with wrap on each expiry
    always_ff @(posedge clk) begin
        if (!por_n) begin
            sel_q <= '0;
        end else if (advance) begin
            sel_q <= (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
        end
    end

    // Sticky record that an expiry has ever happened
    always_ff @(posedge clk) begin
        if (!por_n) begin
            expired_q <= 1'b0;
        end else if (advance) begin
            expired_q <= 1'b1;
        end
    end

    assign sel_o     = sel_q;
    assign expired_o = expired_q;

endmodule

// File: rtl/bootfail_wdog.sv
// Module: bootfail_wdog (top)
// Board-level boot failover watchdog. Arms on power-on or external
// reset release, pulses a board reset on timeout, and moves the boot
// source to the next flash device. Software disarms it once; a
// mezzanine-present level forces it off.
// Assumes: por_n and brd_rst_n are synchronous to clk; mezz_present is not.
module bootfail_wdog
    import bfw_pkg::*;
#(
    parameter int NUM_DEV     = 3,
    parameter int TIMEOUT_CYC = 62_500_000,
    parameter int PULSE_CYC   = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int STAT_W     = ST_SEL_LSB + SEL_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              brd_rst_n,
    input  logic              disarm_we,
    input  logic              mezz_present,
    output logic              reset_req,
    output logic [SEL_W-1:0]  boot_sel,
    output logic [STAT_W-1:0] status
);

    logic forced;
    logic expire;
    logic armed;
    logic expired;

    bfw_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (mezz_present),
        .q     (forced)
    );

    bfw_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .PULSE_CYC   (PULSE_CYC)
    ) u_timer (
        .clk         (clk),
        .por_n       (por_n),
        .brd_rst_n   (brd_rst_n),
        .disarm_we   (disarm_we),
        .forced      (forced),
        .expire_o    (expire),
        .reset_req_o (reset_req),
        .armed_o     (armed)
    );

    bfw_bootsel #(
        .NUM_DEV (NUM_DEV)
    ) u_bootsel (
        .clk       (clk),
        .por_n     (por_n),
        .advance   (expire),
        .sel_o     (boot_sel),
        .expired_o (expired)
    );

    // Assemble the status word from the fixed field positions
    always_comb begin
        status                          = '0;
        status[ST_ARMED]                = armed;
        status[ST_FORCED]               = forced;
        status[ST_EXPIRED]              = expired;
        status[ST_SEL_LSB +: SEL_W]     = boot_sel;
    end

endmodule

// File: rtl/bfw_chk.sv
// Module: bfw_chk
// Protocol checker for bootfail_wdog, attached by bind. Watches only
// the top-level ports.
// Assumes: the same parameters as the bound instance.
module bfw_chk #(
    parameter int NUM_DEV   = 3,
    parameter int PULSE_CYC = 16,
    localparam int SEL_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int STAT_W   = 3 + SEL_W
) (
    input logic              clk,
    input logic              por_n,
    input logic              brd_rst_n,
    input logic              reset_req,
    input logic [SEL_W-1:0]  boot_sel,
    input logic [STAT_W-1:0] status
);

    localparam int RUN_W = $clog2(PULSE_CYC + 2);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_DEV - 1);

    logic [RUN_W-1:0] run_len;

    // Length of the current run of reset_req high
    always_ff @(posedge clk) begin
        if (!por_n) begin
            run_len <= '0;
        end else if (reset_req) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(reset_req) && $past(brd_rst_n)) |-> (run_len == RUN_W'(PULSE_CYC)));

    // R3
    sel_only_on_expiry_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(boot_sel) |-> $rose(reset_req));

    // R3
    sel_wrap_step_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reset_req) |->
            (boot_sel == (($past(boot_sel) == SEL_LAST) ? '0 : $past(boot_sel) + 1'b1)));

    // R3
    sel_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        boot_sel <= SEL_LAST);

    // R5
    disarm_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!status[0] && brd_rst_n) |=> !status[0]);

    // R4
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        status[2] |=> status[2]);

    // R10
    expired_on_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reset_req) |-> status[2]);

    // R8
    no_pulse_when_forced_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reset_req) |-> !$past(status[1]));

endmodule

bind bootfail_wdog bfw_chk #(
    .NUM_DEV   (NUM_DEV),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .brd_rst_n (brd_rst_n),
    .reset_req (reset_req),
    .boot_sel  (boot_sel),
    .status    (status)
);

// File: tb/bootfail_wdog_test.sv
// Bench: scoreboard of expected reset pulses for bootfail_wdog.
module bootfail_wdog_test;

    localparam int ND    = 3;
    localparam int TO    = 40;
    localparam int PW    = 4;
    localparam int SW    = 2;
    localparam int STW   = 3 + SW;

    logic           clk = 1'b0;
    logic           por_n = 1'b0;
    logic           brd_rst_n = 1'b1;
    logic           disarm_we = 1'b0;
    logic           mezz_present = 1'b0;
    logic           reset_req;
    logic [SW-1:0]  boot_sel;
    logic [STW-1:0] status;

    int edges = 0;
    int n_chk = 0;
    int n_fail = 0;
    int rises = 0;
    bit done = 1'b0;

    typedef struct {
        int edge_no;
        int sel;
    } exp_t;
    exp_t exp_q[$];

    bootfail_wdog #(
        .NUM_DEV     (ND),
        .TIMEOUT_CYC (TO),
        .PULSE_CYC   (PW),
        .SYNC_STAGES (2)
    ) uut (
        .clk          (clk),
        .por_n        (por_n),
        .brd_rst_n    (brd_rst_n),
        .disarm_we    (disarm_we),
        .mezz_present (mezz_present),
        .reset_req    (reset_req),
        .boot_sel     (boot_sel),
        .status       (status)
    );

    always #4 clk = ~clk;

    always @(posedge clk) edges <= edges + 1;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Driver side: push an expected rise
    task automatic expect_rise(input int at_edge, input int sel);
        exp_t e;
        e.edge_no = at_edge;
        e.sel     = sel;
        exp_q.push_back(e);
    endtask

    task automatic wait_until(input int target);
        while (edges < target) @(negedge clk);
    endtask

    task automatic pulse_disarm();
        disarm_we = 1'b1;
        @(negedge clk);
        disarm_we = 1'b0;
    endtask

    // Monitor: pop and compare on each rise, measure pulse width
    bit prev_req = 1'b0;
    int run = 0;
    always @(negedge clk) begin
        exp_t e;
        if (por_n) begin
            if (reset_req && !prev_req) begin
                rises++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 R6 R7 R8 unexpected reset rise at edge", edges, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(edges == e.edge_no, "R1 R2 rise edge", edges, e.edge_no);
                    check(int'(boot_sel) == e.sel, "R3 boot_sel at rise", int'(boot_sel), e.sel);
                end
            end
            if (reset_req) run++;
            if (prev_req && !reset_req) begin
                check(run == PW, "R2 pulse width", run, PW);
                run = 0;
            end
            prev_req = reset_req;
        end else begin
            prev_req = 1'b0;
            run = 0;
        end
    end

    initial begin
        int rel;
        int t;
        int r0;
        repeat (3) @(negedge clk);
        check(reset_req == 1'b0, "R9 reset_req in reset", int'(reset_req), 0);
        check(int'(boot_sel) == 0, "R4 boot_sel after por", int'(boot_sel), 0);
        check(int'(status) == 1, "R9 status after por", int'(status), 1);

        // R1 R3: free-running expiries with wrap
        por_n = 1'b1;
        rel = edges;
        expect_rise(rel + TO, 1);
        expect_rise(rel + 2*TO + PW, 2);
        expect_rise(rel + 3*TO + 2*PW, 0);
        wait_until(rel + 3*TO + 2*PW + 2);
        check(exp_q.size() == 0, "R1 all expiries seen", exp_q.size(), 0);
        check(int'(status) == 5'b00101, "R9 R10 status after wrap", int'(status), 5'b00101);
        wait_until(rel + 3*TO + 3*PW + 4);

        // R4: external reset keeps selector and flag
        brd_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        brd_rst_n = 1'b1;
        rel = edges;
        check(int'(boot_sel) == 0, "R4 boot_sel after board reset", int'(boot_sel), 0);
        check(status[2] == 1'b1, "R4 expired after board reset", int'(status[2]), 1);
        expect_rise(rel + TO, 1);
        expect_rise(rel + 2*TO + PW, 2);
        // R11: write during pulse is ignored
        wait_until(rel + TO + 1);
        pulse_disarm();
        wait_until(rel + TO + PW + 2);
        check(status[0] == 1'b1, "R11 still armed after write in pulse", int'(status[0]), 1);
        wait_until(rel + 2*TO + 2*PW + 12);
        check(exp_q.size() == 0, "R11 second expiry seen", exp_q.size(), 0);

        // R5: disarm, then later writes change nothing
        pulse_disarm();
        @(negedge clk);
        check(status[0] == 1'b0, "R5 disarmed", int'(status[0]), 0);
        r0 = rises;
        repeat (150) @(negedge clk);
        pulse_disarm();
        repeat (100) @(negedge clk);
        check(rises == r0, "R5 no expiry after disarm", rises, r0);
        check(status[0] == 1'b0 && int'(boot_sel) == 2, "R5 state after extra write",
              int'(status[0]), 0);

        // R6: disarm on the expiry edge wins
        brd_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        brd_rst_n = 1'b1;
        rel = edges;
        @(negedge clk);
        check(status[0] == 1'b1, "R5 re-armed by board reset", int'(status[0]), 1);
        wait_until(rel + TO - 1);
        pulse_disarm();
        r0 = rises;
        repeat (100) @(negedge clk);
        check(rises == r0, "R6 no pulse on collision", rises, r0);
        check(int'(boot_sel) == 2, "R6 boot_sel kept", int'(boot_sel), 2);
        check(status[0] == 1'b0, "R6 disarm took effect", int'(status[0]), 0);

        // R7: external reset on the expiry edge wins
        brd_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        brd_rst_n = 1'b1;
        rel = edges;
        wait_until(rel + TO - 1);
        brd_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        brd_rst_n = 1'b1;
        rel = edges;
        check(int'(boot_sel) == 2, "R7 boot_sel kept", int'(boot_sel), 2);
        check(rises == r0, "R7 no pulse on collision", rises, r0);
        expect_rise(rel + TO, 0);
        wait_until(rel + TO + PW + 6);
        check(exp_q.size() == 0 && int'(boot_sel) == 0, "R7 R3 restart and wrap",
              int'(boot_sel), 0);

        // R8: presence forces the watchdog off
        mezz_present = 1'b1;
        r0 = rises;
        repeat (300) @(negedge clk);
        check(status[1] == 1'b1, "R8 forced bit", int'(status[1]), 1);
        check(status[0] == 1'b1, "R8 armed while forced", int'(status[0]), 1);
        check(rises == r0 && int'(boot_sel) == 0, "R8 no expiry while forced", rises - r0, 0);
        mezz_present = 1'b0;
        t = edges;
        expect_rise(t + 2 + TO, 1);
        wait_until(t + 3);
        check(status[1] == 1'b0, "R8 forced bit clears", int'(status[1]), 0);
        wait_until(t + 2 + TO + PW + 4);
        check(exp_q.size() == 0, "R8 countdown after release", exp_q.size(), 0);

        // R4: power-on reset clears selector and flag
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(boot_sel) == 0, "R4 boot_sel cleared by por", int'(boot_sel), 0);
        check(int'(status) == 1, "R4 R9 status cleared by por", int'(status), 1);
        por_n = 1'b1;
        rel = edges;
        expect_rise(rel + TO, 1);
        wait_until(rel + TO + PW + 4);
        check(exp_q.size() == 0, "R1 expiry after por", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog for a hung run
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", edges, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule